// File: doc/BRIEF.md
# Next-PC Selection Unit

This unit holds the program counter of a single-cycle processor and works out, in the same cycle, the address that the counter takes at the next rising clock edge. It chooses between four ways of forming that address: stepping to the next sequential word, adding a scaled branch displacement, copying a register value, or placing a jump index inside the current 256 MB region. All additions wrap modulo 2^32 and raise no flag.

Decode logic supplies a small control class. The rest of the datapath supplies the displacement and jump-index fields of the current instruction, the value of the source register and a flag that says whether that register is zero. Conditional branches test only this flag. They never compare two registers. The unit returns the current PC, the PC+4 link value for call instructions, and the selected next PC.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes 0 at that edge, whatever the other inputs are.
- R2: Class code 0 (sequential) selects PC+4 as the next PC.
- R3: Class code 1 (branch-if-zero) selects PC+4 + (sign-extended `br_offset` × 4) when `rs_zero` is 1, and PC+4 when `rs_zero` is 0. The sum wraps modulo 2^32.
- R4: Class code 2 (branch-if-nonzero) selects the branch target of R3 when `rs_zero` is 0, and PC+4 when `rs_zero` is 1.
- R5: Class code 3 (register jump) selects `rs_val` unchanged. `rs_zero` has no effect on it.
- R6: Class code 4 (absolute jump) selects {PC+4 bits 31:28, `jmp_target`, 2'b00}. The region bits come from PC+4, not from PC.
- R7: `pc_link` always equals PC+4 modulo 2^32, so the PC 0xFFFFFFFC gives 0.
- R8: `next_pc` shows, during the cycle, the value that `pc` loads at the next rising edge when reset is low.
- R9: Class codes 5, 6 and 7 are treated as sequential and select PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_class | input | 3 | Control class: 0 seq, 1 branch-if-zero, 2 branch-if-nonzero, 3 register jump, 4 absolute jump |
| rs_zero | input | 1 | High when the source register is zero |
| rs_val | input | 32 | Source register value, used by register jumps |
| br_offset | input | 16 | Signed branch displacement, counted in words |
| jmp_target | input | 26 | Absolute jump word index |
| pc | output | 32 | Current program counter |
| pc_link | output | 32 | PC+4, offered as the link value |
| next_pc | output | 32 | Address the PC takes at the next edge |

## Verification
Each branch class is driven with the zero flag both set and clear, so a swapped or inverted condition shows up as a wrong taken/not-taken result. Displacements include small positive values, -1, the most negative value and the most positive value. These separate correct sign extension and ×4 scaling from zero extension or a missing shift, and two of the cases cross the 2^32 boundary to prove wrap-around. Absolute jumps are placed so that PC and PC+4 lie in different 256 MB regions, which shows which of the two supplies the upper bits. Register jumps run with a misleading zero flag, the unused class codes are applied, and a reset is asserted during a run.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_BRZ  = 3'd1,
    CLS_BRNZ = 3'd2,
    CLS_RJMP = 3'd3,
    CLS_AJMP = 3'd4
  } ctl_class_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'b00,
    SRC_BR  = 2'b01,
    SRC_REG = 2'b10,
    SRC_ABS = 2'b11
  } npc_src_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int TGT_W = 26,
  parameter int SH    = 2
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFS_W-1:0] br_offset,
  input  logic [TGT_W-1:0] jmp_target,
  output logic [XLEN-1:0]  seq_addr,
  output logic [XLEN-1:0]  br_addr,
  output logic [XLEN-1:0]  abs_addr
);
  localparam int EXT_W    = XLEN - OFS_W - SH;
  localparam int REGION_W = XLEN - TGT_W - SH;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << SH;

  logic [XLEN-1:0] disp;

  assign seq_addr = pc + STEP;
  assign disp     = {{EXT_W{br_offset[OFS_W-1]}}, br_offset, {SH{1'b0}}};
  assign br_addr  = seq_addr + disp;

  generate
    if (REGION_W > 0) begin : g_region
      assign abs_addr = {seq_addr[XLEN-1 -: REGION_W], jmp_target, {SH{1'b0}}};
    end else begin : g_flat
      assign abs_addr = {jmp_target, {SH{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      ctl_class,
  input  logic            rs_zero,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] br_addr,
  input  logic [XLEN-1:0] reg_addr,
  input  logic [XLEN-1:0] abs_addr,
  output logic [XLEN-1:0] sel_addr
);
  npc_src_e src;

  always_comb begin
    unique case (ctl_class)
      CLS_BRZ:  src = rs_zero ? SRC_BR : SRC_SEQ;
      CLS_BRNZ: src = rs_zero ? SRC_SEQ : SRC_BR;
      CLS_RJMP: src = SRC_REG;
      CLS_AJMP: src = SRC_ABS;
      default:  src = SRC_SEQ;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_BR:  sel_addr = br_addr;
      SRC_REG: sel_addr = reg_addr;
      SRC_ABS: sel_addr = abs_addr;
      default: sel_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int TGT_W = 26,
  parameter int SH    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ctl_class,
  input  logic             rs_zero,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [OFS_W-1:0] br_offset,
  input  logic [TGT_W-1:0] jmp_target,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  pc_link,
  output logic [XLEN-1:0]  next_pc
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] abs_addr;

  npc_targets #(
    .XLEN(XLEN), .OFS_W(OFS_W), .TGT_W(TGT_W), .SH(SH)
  ) u_targets (
    .pc(pc_q),
    .br_offset(br_offset),
    .jmp_target(jmp_target),
    .seq_addr(seq_addr),
    .br_addr(br_addr),
    .abs_addr(abs_addr)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .ctl_class(ctl_class),
    .rs_zero(rs_zero),
    .seq_addr(seq_addr),
    .br_addr(br_addr),
    .reg_addr(rs_val),
    .abs_addr(abs_addr),
    .sel_addr(next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  assign pc      = pc_q;
  assign pc_link = seq_addr;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      ctl_class,
  input logic            rs_zero,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] pc_link,
  input logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pc == '0);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == 3'd0) |=> pc == $past(pc) + FOUR);

  a_r3_brz_not_taken: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == 3'd1 && !rs_zero) |=> pc == $past(pc) + FOUR);

  a_r4_brnz_not_taken: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == 3'd2 && rs_zero) |=> pc == $past(pc_link));

  a_r5_reg_jump: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == 3'd3) |=> pc == $past(rs_val));

  a_r6_abs_region: assert property (@(posedge clk) disable iff (rst)
    (ctl_class == 3'd4) |=> (pc[XLEN-1 -: 4] == $past(pc_link[XLEN-1 -: 4])) && (pc[1:0] == 2'b00));

  a_r8_commit: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == $past(next_pc));

  a_r9_spare_seq: assert property (@(posedge clk) disable iff (rst)
    (ctl_class > 3'd4) |=> pc == $past(pc) + FOUR);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .ctl_class(ctl_class), .rs_zero(rs_zero),
  .rs_val(rs_val), .pc(pc), .pc_link(pc_link), .next_pc(next_pc)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ctl_class = 3'd0;
  logic        rs_zero = 1'b0;
  logic [31:0] rs_val = '0;
  logic [15:0] br_offset = '0;
  logic [25:0] jmp_target = '0;
  logic [31:0] pc, pc_link, next_pc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst(rst), .ctl_class(ctl_class), .rs_zero(rs_zero),
    .rs_val(rs_val), .br_offset(br_offset), .jmp_target(jmp_target),
    .pc(pc), .pc_link(pc_link), .next_pc(next_pc)
  );

  // start pc, class, offset, target, rs, zero, expected next
  localparam int NV = 15;
  localparam logic [141:0] VEC [NV] = '{
    {32'h00001000, 3'd0, 16'h0000, 26'h0000000, 32'h0, 1'b0, 32'h00001004}, // R2
    {32'h00001000, 3'd1, 16'h0010, 26'h0000000, 32'h0, 1'b1, 32'h00001044}, // R3 taken
    {32'h00001000, 3'd1, 16'h0010, 26'h0000000, 32'h5, 1'b0, 32'h00001004}, // R3 not taken
    {32'h00001000, 3'd2, 16'hFFFF, 26'h0000000, 32'h5, 1'b0, 32'h00001000}, // R4 taken, -1
    {32'h00001000, 3'd2, 16'hFFFF, 26'h0000000, 32'h0, 1'b1, 32'h00001004}, // R4 not taken
    {32'h00002000, 3'd1, 16'h8000, 26'h0000000, 32'h0, 1'b1, 32'hFFFE2004}, // R3 most negative
    {32'h00000100, 3'd1, 16'h7FFF, 26'h0000000, 32'h0, 1'b1, 32'h00020100}, // R3 most positive
    {32'hFFFFFFF0, 3'd2, 16'h0008, 26'h0000000, 32'h1, 1'b0, 32'h00000014}, // R4 wrap
    {32'h12345678, 3'd3, 16'h0000, 26'h0000000, 32'hDEADBEEC, 1'b1, 32'hDEADBEEC}, // R5
    {32'hA0000010, 3'd4, 16'h0000, 26'h3FFFFFF, 32'h0, 1'b0, 32'hAFFFFFFC}, // R6
    {32'h0FFFFFFC, 3'd4, 16'h0000, 26'h0000001, 32'h0, 1'b0, 32'h10000004}, // R6 PC+4 region
    {32'hFFFFFFFC, 3'd0, 16'h0000, 26'h0000000, 32'h0, 1'b0, 32'h00000000}, // R7 wrap
    {32'h00000040, 3'd5, 16'h0010, 26'h0000010, 32'h9, 1'b1, 32'h00000044}, // R9
    {32'h00000040, 3'd6, 16'h0010, 26'h0000010, 32'h9, 1'b0, 32'h00000044}, // R9
    {32'h00000040, 3'd7, 16'h0010, 26'h0000010, 32'h9, 1'b1, 32'h00000044}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pc(input logic [31:0] v);
    @(negedge clk);
    ctl_class = 3'd3; rs_val = v; rs_zero = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset pc", pc, 32'h0);
    check("R7 link at reset", pc_link, 32'h4);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] start, exp;
      start = VEC[i][141:110];
      exp   = VEC[i][31:0];
      load_pc(start);
      @(negedge clk);
      ctl_class  = VEC[i][109:107];
      br_offset  = VEC[i][106:91];
      jmp_target = VEC[i][90:65];
      rs_val     = VEC[i][64:33];
      rs_zero    = VEC[i][32];
      #1;
      check("R7 link", pc_link, start + 32'd4);
      check($sformatf("R8 next_pc vec%0d (R2-R6,R9)", i), next_pc, exp);
      @(posedge clk); #1;
      check($sformatf("R8 pc loaded vec%0d", i), pc, exp);
    end

    // R5: zero flag clear with zero register value still jumps
    load_pc(32'h00000000);
    check("R5 rjump to zero", pc, 32'h0);

    // R2: consecutive sequential steps
    @(negedge clk); ctl_class = 3'd0;
    @(posedge clk); #1;
    check("R2 step 1", pc, 32'h4);
    @(posedge clk); #1;
    check("R2 step 2", pc, 32'h8);

    // R1: reset during a run overrides a jump request
    load_pc(32'h55555554);
    @(negedge clk); rst = 1'b1; ctl_class = 3'd3; rs_val = 32'h11111110;
    @(posedge clk); #1;
    check("R1 mid-run reset", pc, 32'h0);
    @(negedge clk); rst = 1'b0; ctl_class = 3'd0;
    @(posedge clk); #1;
    check("R1 resume after reset", pc, 32'h4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule